// File: doc/BRIEF.md
# Watchdog Timer with Stretched Reset

This block guards a system against software that stops responding. A counter advances on each tick of a slow, free-running time base. The tick arrives as a single-cycle enable in the fast system clock domain. Software must strobe a kick input before the count reaches a terminal value. The terminal value is chosen from ten power-of-two periods.

If the chosen period runs out without a kick, the block emits a timeout pulse that is exactly one system clock wide. When that pulse falls, a second counter starts. It keeps a chip-level reset output asserted for a fixed number of time-base ticks and then releases it. While that reset is held, the watchdog count stays at zero. Counting starts again from zero once the reset is released.

The watchdog enable, the kick and an asynchronous system reset all return the count to zero. The period select may change at any time, and the new value applies at once.

Top module: `wdt_stretch`

## Requirements
- R1: The watchdog count and the hold count advance only on clock edges at which `tick` is 1.
- R2: For `per_sel` = s with s in 0..9, the timeout pulse is asserted in the cycle after the edge that samples the 2^(BASE_SHIFT+s)-th tick counted since the count was last cleared.
- R3: An edge that samples `kick` = 1 clears the count to zero, so kicks that arrive more often than the period prevent any timeout.
- R4: An edge that samples `wd_en` = 0 clears the count, and no timeout pulse follows such an edge.
- R5: `timeout_pulse` is never high for two cycles in a row.
- R6: `rst_hold` is 1 during the pulse cycle. It stays 1 after the pulse falls, and drops after the edge that samples the HOLD_TICKS-th tick counted after the pulse's falling edge. It therefore drops at a tick edge.
- R7: While `rst_hold` is 1, the count is held at zero and no pulse is raised. Counting resumes from zero at the first tick after release.
- R8: A kick sampled at the same edge as an expiring tick wins: no pulse is raised, and a full period starts again.
- R9: Select codes 10 to 15 give the same period as code 9.
- R10: A new `per_sel` value applies at the next edge. A count already at or beyond the new terminal value expires on the next tick.
- R11: While `rst_n` is 0, both outputs are 0 and the count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| tick | input | 1 | Single-cycle enable from the slow time base |
| wd_en | input | 1 | Watchdog enable; 0 holds the count cleared |
| kick | input | 1 | Software service strobe; clears the count |
| per_sel | input | 4 | Timeout period select, 0..9 (10..15 clamp to 9) |
| timeout_pulse | output | 1 | One-cycle expiry pulse |
| rst_hold | output | 1 | Stretched reset output |

## Verification
The count is cleared at the edge that samples the kick. With a tick on every edge, the pulse then appears 2^(BASE_SHIFT+s) edges after the kick edge. With a tick every third edge, it appears three times as many edges later. With a tick on every edge, `rst_hold` stays high for HOLD_TICKS+1 cycles, and the next pulse after release is due one full period after the release edge. The driver aligns each kick to a known edge number and queues the edge at which each pulse is due. A monitor samples on the falling clock edge, matches every observed pulse against the head of that queue, and times each `rst_hold` interval. A pulse that arrives with nothing queued, or on the wrong edge, is reported as a failure.

// File: rtl/wdt_stretch.sv
module wdt_stretch #(
  parameter int BASE_SHIFT = 11,
  parameter int NUM_TAPS   = 10,
  parameter int HOLD_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wd_en,
  input  logic       kick,
  input  logic [3:0] per_sel,
  output logic       timeout_pulse,
  output logic       rst_hold
);
  localparam int CNT_W  = BASE_SHIFT + NUM_TAPS;
  localparam int HOLD_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [3:0] MAX_SEL = 4'(NUM_TAPS - 1);
  localparam logic [7:0] BASE8 = 8'(BASE_SHIFT);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic [3:0]        eff_sel;
  logic [7:0]        shamt;
  logic [HOLD_W-1:0] hold_cnt;
  logic              running, busy, expire;

  assign eff_sel = (per_sel > MAX_SEL) ? MAX_SEL : per_sel;
  assign shamt   = BASE8 + {4'd0, eff_sel};
  assign limit   = (ONE << shamt) - ONE;
  assign busy    = timeout_pulse | running;
  assign expire  = wd_en & tick & ~kick & ~busy & (cnt >= limit);
  assign rst_hold = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!wd_en || kick || busy || expire) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timeout_pulse <= 1'b0;
    else        timeout_pulse <= expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      hold_cnt <= '0;
    end else if (timeout_pulse) begin
      running  <= 1'b1;
      hold_cnt <= '0;
    end else if (running && tick) begin
      if (hold_cnt == HOLD_LAST) running <= 1'b0;
      else                       hold_cnt <= hold_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_stretch_chk.sv
module wdt_stretch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wd_en,
  input logic       kick,
  input logic [3:0] per_sel,
  input logic       timeout_pulse,
  input logic       rst_hold
);
  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);
  // R6
  hold_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> rst_hold);
  // R6
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_hold) |-> $past(tick));
  // R7
  no_pulse_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hold |=> !timeout_pulse);
  // R1
  tick_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !timeout_pulse);
  // R4
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> !timeout_pulse);
  // R8
  kick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !timeout_pulse);
endmodule

bind wdt_stretch wdt_stretch_chk u_chk (.*);

// File: tb/wdt_stretch_tb.sv
`timescale 1ns/1ps
module wdt_stretch_tb;
  localparam int BS = 2;
  localparam int HT = 8;

  logic clk = 1'b0;
  logic rst_n, tick, wd_en, kick;
  logic [3:0] per_sel;
  logic timeout_pulse, rst_hold;

  always #2 clk = ~clk;

  wdt_stretch #(.BASE_SHIFT(BS), .NUM_TAPS(10), .HOLD_TICKS(HT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wd_en(wd_en), .kick(kick),
    .per_sel(per_sel), .timeout_pulse(timeout_pulse), .rst_hold(rst_hold));

  int cyc = 0;
  int tp = 1;
  int n_chk = 0, n_err = 0;
  int exp_q[$];
  int hold_exp = HT + 1;
  int hold_start = 0;
  logic pulse_prev = 1'b0, hold_prev = 1'b0;
  string cur_req = "R2";

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick = ((cyc + 1) % tp == 0);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      pulse_prev = 1'b0;
      hold_prev  = 1'b0;
    end else begin
      if (timeout_pulse) begin
        if (pulse_prev) check(0, "R5 pulse width", 2, 1);
        else if (exp_q.size() == 0) check(0, {cur_req, " unexpected pulse"}, cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cyc == e, {cur_req, " pulse edge"}, cyc, e);
        end
      end
      if (rst_hold && !hold_prev) hold_start = cyc;
      if (!rst_hold && hold_prev && hold_exp > 0)
        check(cyc - hold_start == hold_exp, "R6 hold length", cyc - hold_start, hold_exp);
      pulse_prev = timeout_pulse;
      hold_prev  = rst_hold;
    end
  end

  task automatic kick_now(output int ke);
    @(negedge clk);
    while ((cyc + 1) % tp != 0) @(negedge clk);
    kick = 1'b1;
    wd_en = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    ke = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic close_test(input int settle);
    wd_en = 1'b0;
    repeat (settle) @(negedge clk);
    check(exp_q.size() == 0, {cur_req, " missing pulse"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int ke, p1, p2;
    rst_n = 1'b0; wd_en = 1'b0; kick = 1'b0; per_sel = 4'd0; tick = 1'b1;
    repeat (3) @(negedge clk);
    check(timeout_pulse == 0 && rst_hold == 0, "R11 reset outputs", {timeout_pulse, rst_hold}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R5 R6 R7: basic period, hold, restart after release
    cur_req = "R7"; per_sel = 4'd0;
    kick_now(ke);
    p1 = ke + 4; p2 = p1 + (HT + 1) + 4;
    exp_q.push_back(p1); exp_q.push_back(p2);
    wait_until(p2 + 3);
    close_test(40);

    // R1: tick every third edge
    cur_req = "R1"; tp = 3; hold_exp = 3 * HT; per_sel = 4'd2;
    kick_now(ke);
    exp_q.push_back(ke + 3 * 16);
    wait_until(ke + 50);
    close_test(100);
    tp = 1; hold_exp = HT + 1;

    // R2 longest tap
    cur_req = "R2"; per_sel = 4'd9;
    kick_now(ke);
    exp_q.push_back(ke + 2048);
    wait_until(ke + 2050);
    close_test(30);

    // R9 clamped code
    cur_req = "R9"; per_sel = 4'd12;
    kick_now(ke);
    exp_q.push_back(ke + 2048);
    wait_until(ke + 2050);
    close_test(30);

    // R3 regular kicks prevent expiry
    cur_req = "R3"; per_sel = 4'd1;
    for (int i = 0; i < 12; i++) begin
      kick_now(ke);
      repeat (4) @(negedge clk);
    end
    kick_now(ke);
    exp_q.push_back(ke + 8);
    wait_until(ke + 10);
    close_test(30);

    // R4 brief disable restarts the period
    cur_req = "R4"; per_sel = 4'd0;
    kick_now(ke);
    wait_until(ke + 2);
    wd_en = 1'b0;
    @(negedge clk);
    wd_en = 1'b1;
    exp_q.push_back(ke + 7);
    wait_until(ke + 9);
    close_test(30);

    // R8 kick at the expiring edge wins
    cur_req = "R8";
    kick_now(ke);
    wait_until(ke + 3);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    exp_q.push_back(ke + 8);
    wait_until(ke + 10);
    close_test(30);

    // R10 shorter period applied mid count
    cur_req = "R10"; per_sel = 4'd3;
    kick_now(ke);
    wait_until(ke + 10);
    per_sel = 4'd0;
    exp_q.push_back(ke + 11);
    wait_until(ke + 13);
    close_test(30);

    // R11 reset mid count, then reset during hold
    cur_req = "R11";
    kick_now(ke);
    wait_until(ke + 2);
    rst_n = 1'b0;
    #1;
    check(timeout_pulse == 0 && rst_hold == 0, "R11 mid-count reset", {timeout_pulse, rst_hold}, 0);
    @(negedge clk);
    rst_n = 1'b1; kick = 1'b1; wd_en = 1'b1;
    @(negedge clk);
    kick = 1'b0; ke = cyc;
    exp_q.push_back(ke + 4);
    wait_until(ke + 6);
    check(rst_hold == 1, "R6 hold active", rst_hold, 1);
    hold_exp = 0;
    rst_n = 1'b0;
    #1;
    check(timeout_pulse == 0 && rst_hold == 0, "R11 reset in hold", {timeout_pulse, rst_hold}, 0);
    @(negedge clk);
    rst_n = 1'b1; kick = 1'b1;
    @(negedge clk);
    kick = 1'b0; ke = cyc;
    hold_exp = HT + 1;
    exp_q.push_back(ke + 4);
    wait_until(ke + 6);
    close_test(30);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule